// File: doc/BRIEF.md
# Disciplined Millisecond Clock with Offset Slewing

This block keeps time of day as a 48-bit count of whole milliseconds, refined by a 32-bit fraction register that sits beneath it. On every hardware tick, the fraction register receives a fixed nominal increment plus a signed adjustment term. When that sum carries past the top of the fraction, the millisecond count advances by a configured step. Because the adjustment term is signed, changing it speeds the clock up or slows it down without ever making the indicated time jump.

A signed phase offset is written in through a load port. It stays pending until the next local-second strobe. At that strobe a two-regime controller acts on it. If the offset is large, the adjustment term is nudged up or down by a fixed step, and the offset stays pending so the nudge repeats every second. If the offset is small, the adjustment term is set to the offset shifted right arithmetically by a power-of-two divisor, and the pending offset is cleared. A separate load port lets software place a previously saved adjustment value at startup, which shortens convergence.

Top module: `msclk_discipline`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `time_ms_o`, `frac_o`, `adj_o` and `pend_o` are all zero.
- R2: When `adj_load_i` is high, `adj_o` equals `adj_load_val_i` in the next cycle. This has priority over any change the second strobe would make to `adj_o`.
- R3: When `tick_i` is high, `frac_o` becomes (`frac_o` + TICK_INC + signed `adj_o`) modulo 2^32. Without a tick, `frac_o` and `time_ms_o` hold their values.
- R4: On a tick, `time_ms_o` advances by MS_INC (modulo 2^48) only when the exact sum from R3, taken as a signed integer, is at least 2^32. A sum that is negative because of a negative adjustment wraps the fraction but does not advance the clock, and at most one step is taken per tick.
- R5: `ofs_load_i` without `sec_i` sets `pend_o` to `ofs_i` in the next cycle and leaves `adj_o` unchanged.
- R6: At a second strobe, if the evaluated offset (two's complement) has a magnitude of at least SLEW_LIMIT, `adj_o` grows by SLEW_STEP when the offset is positive and shrinks by SLEW_STEP when it is negative, modulo 2^32. The offset remains pending.
- R7: At a second strobe, if the magnitude is below SLEW_LIMIT, `adj_o` becomes the offset arithmetically shifted right by PHI_SHIFT, and `pend_o` becomes zero.
- R8: When `ofs_load_i` and `sec_i` arrive in the same cycle, the strobe evaluates `ofs_i` and not the previously pending offset.
- R9: When `tick_i` and `sec_i` arrive in the same cycle, the tick uses the value of `adj_o` from before that strobe.
- R10: Without `sec_i` or `adj_load_i`, `adj_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Hardware tick strobe |
| sec_i | input | 1 | Local one-second strobe |
| ofs_load_i | input | 1 | Load a new pending offset |
| ofs_i | input | 32 | Signed offset value |
| adj_load_i | input | 1 | Preload the adjustment register |
| adj_load_val_i | input | 32 | Signed saved adjustment value |
| time_ms_o | output | 48 | Millisecond time-of-day count |
| frac_o | output | 32 | Fraction (prescaler) register |
| adj_o | output | 32 | Signed per-tick adjustment register |
| pend_o | output | 32 | Signed pending offset |

## Verification
Two pairs of events can land on the same edge. An offset load can coincide with the second strobe, and a tick can coincide with the second strobe. The bench provokes the first pair by sweeping every offset from -140 to 140, plus both extremes of the 32-bit range, as a combined load and strobe, starting each time from a nonzero pending offset. It judges the resulting adjustment and pending values against an arithmetic model. For the second pair, it issues ticks on the strobe cycle while a large offset is pending, and checks that the fraction advanced by the adjustment value from before the strobe.

// File: rtl/msclk_pkg.sv
package msclk_pkg;

    localparam int unsigned DEF_CLK_W  = 48;
    localparam int unsigned DEF_FRAC_W = 32;

    // action chosen by the once-per-second controller
    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2,
        SLEW_PROP = 2'd3
    } slew_act_e;

    // outcome of one tick of the fractional accumulator
    typedef struct packed {
        logic                  carry;
        logic [DEF_FRAC_W-1:0] frac;
    } acc_res_t;

endpackage

// File: rtl/msclk_prescale.sv
module msclk_prescale
    import msclk_pkg::*;
#(
    parameter int unsigned          CLK_W    = DEF_CLK_W,
    parameter int unsigned          FRAC_W   = DEF_FRAC_W,
    parameter logic [FRAC_W-1:0]    TICK_INC = 32'h3333_3333,
    parameter logic [CLK_W-1:0]     MS_INC   = 48'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [FRAC_W-1:0] adj_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [CLK_W-1:0]  time_ms_o
);

    // three guard bits: sign plus room for two full-width unsigned terms
    localparam int unsigned SUM_W = FRAC_W + 3;

    logic [FRAC_W-1:0]       frac_q;
    logic [CLK_W-1:0]        ms_q;
    logic signed [SUM_W-1:0] sum_s;
    logic                    carry;

    always_comb begin
        sum_s = $signed({3'b000, frac_q})
              + $signed({3'b000, TICK_INC})
              + $signed({{3{adj_i[FRAC_W-1]}}, adj_i});
        // a carry is a non-negative sum that reached 2^FRAC_W
        carry = !sum_s[SUM_W-1] && (sum_s[SUM_W-2:FRAC_W] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            ms_q   <= '0;
        end else if (tick_i) begin
            frac_q <= sum_s[FRAC_W-1:0];
            if (carry) ms_q <= ms_q + MS_INC;
        end
    end

    assign frac_o    = frac_q;
    assign time_ms_o = ms_q;

endmodule

// File: rtl/msclk_slew.sv
module msclk_slew
    import msclk_pkg::*;
#(
    parameter int unsigned OFS_W      = DEF_FRAC_W,
    parameter int unsigned SLEW_LIMIT = 128,
    parameter int unsigned SLEW_STEP  = 8,
    parameter int unsigned PHI_SHIFT  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_i,
    input  logic             ofs_load_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             adj_load_i,
    input  logic [OFS_W-1:0] adj_load_val_i,
    output logic [OFS_W-1:0] adj_o,
    output logic [OFS_W-1:0] pend_o
);

    localparam logic [OFS_W:0]   LIMIT_V = (OFS_W+1)'(SLEW_LIMIT);
    localparam logic [OFS_W-1:0] STEP_V  = OFS_W'(SLEW_STEP);

    logic [OFS_W-1:0] adj_q, pend_q, adj_d, pend_d;
    logic [OFS_W-1:0] eval_ofs;
    logic [OFS_W:0]   mag;
    logic             big;
    slew_act_e        act;

    always_comb begin
        // a fresh load in the strobe cycle is the one evaluated
        eval_ofs = ofs_load_i ? ofs_i : pend_q;
        mag      = eval_ofs[OFS_W-1] ? ({1'b0, ~eval_ofs} + 1'b1) : {1'b0, eval_ofs};
        big      = (mag >= LIMIT_V);

        if (!sec_i)                act = SLEW_HOLD;
        else if (!big)             act = SLEW_PROP;
        else if (eval_ofs[OFS_W-1]) act = SLEW_DOWN;
        else                       act = SLEW_UP;

        unique case (act)
            SLEW_UP:   adj_d = adj_q + STEP_V;
            SLEW_DOWN: adj_d = adj_q - STEP_V;
            SLEW_PROP: adj_d = OFS_W'($signed(eval_ofs) >>> PHI_SHIFT);
            default:   adj_d = adj_q;
        endcase
        if (adj_load_i) adj_d = adj_load_val_i;

        if (sec_i)           pend_d = big ? eval_ofs : '0;
        else if (ofs_load_i) pend_d = ofs_i;
        else                 pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adj_q  <= '0;
            pend_q <= '0;
        end else begin
            adj_q  <= adj_d;
            pend_q <= pend_d;
        end
    end

    assign adj_o  = adj_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/msclk_discipline.sv
module msclk_discipline
    import msclk_pkg::*;
#(
    parameter int unsigned          CLK_W      = DEF_CLK_W,
    parameter int unsigned          FRAC_W     = DEF_FRAC_W,
    parameter logic [FRAC_W-1:0]    TICK_INC   = 32'h3333_3333,
    parameter logic [CLK_W-1:0]     MS_INC     = 48'd1,
    parameter int unsigned          SLEW_LIMIT = 128,
    parameter int unsigned          SLEW_STEP  = 8,
    parameter int unsigned          PHI_SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              sec_i,
    input  logic              ofs_load_i,
    input  logic [FRAC_W-1:0] ofs_i,
    input  logic              adj_load_i,
    input  logic [FRAC_W-1:0] adj_load_val_i,
    output logic [CLK_W-1:0]  time_ms_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [FRAC_W-1:0] adj_o,
    output logic [FRAC_W-1:0] pend_o
);

    logic [FRAC_W-1:0] adj_w;

    msclk_slew #(
        .OFS_W      (FRAC_W),
        .SLEW_LIMIT (SLEW_LIMIT),
        .SLEW_STEP  (SLEW_STEP),
        .PHI_SHIFT  (PHI_SHIFT)
    ) u_slew (
        .clk            (clk),
        .rst            (rst),
        .sec_i          (sec_i),
        .ofs_load_i     (ofs_load_i),
        .ofs_i          (ofs_i),
        .adj_load_i     (adj_load_i),
        .adj_load_val_i (adj_load_val_i),
        .adj_o          (adj_w),
        .pend_o         (pend_o)
    );

    // the accumulator sees the registered adjustment, so a tick in a
    // strobe cycle uses the value from before that strobe
    msclk_prescale #(
        .CLK_W    (CLK_W),
        .FRAC_W   (FRAC_W),
        .TICK_INC (TICK_INC),
        .MS_INC   (MS_INC)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .adj_i     (adj_w),
        .frac_o    (frac_o),
        .time_ms_o (time_ms_o)
    );

    assign adj_o = adj_w;

endmodule

// File: rtl/msclk_discipline_chk.sv
module msclk_discipline_chk #(
    parameter int unsigned       CLK_W      = 48,
    parameter int unsigned       FRAC_W     = 32,
    parameter logic [CLK_W-1:0]  MS_INC     = 48'd1,
    parameter int unsigned       SLEW_LIMIT = 128,
    parameter int unsigned       SLEW_STEP  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              sec_i,
    input logic              ofs_load_i,
    input logic [FRAC_W-1:0] ofs_i,
    input logic              adj_load_i,
    input logic [FRAC_W-1:0] adj_load_val_i,
    input logic [CLK_W-1:0]  time_ms_o,
    input logic [FRAC_W-1:0] frac_o,
    input logic [FRAC_W-1:0] adj_o,
    input logic [FRAC_W-1:0] pend_o
);

    logic [FRAC_W:0] pend_mag;
    logic            pend_small;
    assign pend_mag   = pend_o[FRAC_W-1] ? ({1'b0, ~pend_o} + 1'b1) : {1'b0, pend_o};
    assign pend_small = pend_mag < (FRAC_W+1)'(SLEW_LIMIT);

    // R3: no tick, no movement of fraction or clock
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(time_ms_o) && $stable(frac_o));

    // R4: a tick advances the clock by zero or one step only
    a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (time_ms_o == $past(time_ms_o)) ||
                   (time_ms_o == CLK_W'($past(time_ms_o) + MS_INC)));

    // R2: preload lands next cycle
    a_r2_preload: assert property (@(posedge clk) disable iff (rst)
        adj_load_i |=> adj_o == $past(adj_load_val_i));

    // R5: offset load outside a strobe
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        ofs_load_i && !sec_i |=> pend_o == $past(ofs_i));

    // R6: large positive pending offset slews up, offset kept
    a_r6_slew_up: assert property (@(posedge clk) disable iff (rst)
        sec_i && !ofs_load_i && !adj_load_i && !pend_small && !pend_o[FRAC_W-1]
        |=> adj_o == FRAC_W'($past(adj_o) + FRAC_W'(SLEW_STEP)) && $stable(pend_o));

    // R7: small pending offset is consumed
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        sec_i && !ofs_load_i && pend_small |=> pend_o == '0);

    // R10: adjustment holds between strobes
    a_r10_adj_hold: assert property (@(posedge clk) disable iff (rst)
        !sec_i && !adj_load_i |=> $stable(adj_o));

endmodule

bind msclk_discipline msclk_discipline_chk #(
    .CLK_W      (CLK_W),
    .FRAC_W     (FRAC_W),
    .MS_INC     (MS_INC),
    .SLEW_LIMIT (SLEW_LIMIT),
    .SLEW_STEP  (SLEW_STEP)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .sec_i          (sec_i),
    .ofs_load_i     (ofs_load_i),
    .ofs_i          (ofs_i),
    .adj_load_i     (adj_load_i),
    .adj_load_val_i (adj_load_val_i),
    .time_ms_o      (time_ms_o),
    .frac_o         (frac_o),
    .adj_o          (adj_o),
    .pend_o         (pend_o)
);

// File: tb/msclk_discipline_bench.sv
module msclk_discipline_bench;

    localparam logic [31:0] TICK  = 32'h3333_3333;
    localparam int          LIM   = 128;
    localparam int          STEP  = 8;
    localparam int          SH    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0, sec_i = 1'b0, ofs_load_i = 1'b0, adj_load_i = 1'b0;
    logic [31:0] ofs_i = '0, adj_load_val_i = '0;
    logic [47:0] time_ms_o;
    logic [31:0] frac_o, adj_o, pend_o;

    always #2 clk = ~clk;

    msclk_discipline #(
        .TICK_INC   (TICK),
        .MS_INC     (48'd1),
        .SLEW_LIMIT (LIM),
        .SLEW_STEP  (STEP),
        .PHI_SHIFT  (SH)
    ) u_msclk_discipline (
        .clk(clk), .rst(rst), .tick_i(tick_i), .sec_i(sec_i),
        .ofs_load_i(ofs_load_i), .ofs_i(ofs_i),
        .adj_load_i(adj_load_i), .adj_load_val_i(adj_load_val_i),
        .time_ms_o(time_ms_o), .frac_o(frac_o), .adj_o(adj_o), .pend_o(pend_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [47:0]        m_time;
    logic [31:0]        m_frac;
    logic signed [31:0] m_adj, m_pend;

    string tag_time = "R4", tag_frac = "R3", tag_adj = "R10", tag_pend = "R5";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(time_ms_o == m_time, tag_time, "time", longint'(time_ms_o), longint'(m_time));
        chk(frac_o == m_frac, tag_frac, "frac", longint'(frac_o), longint'(m_frac));
        chk(adj_o == m_adj, tag_adj, "adj", longint'($signed(adj_o)), longint'(m_adj));
        chk(pend_o == m_pend, tag_pend, "pend", longint'($signed(pend_o)), longint'(m_pend));
    endtask

    task automatic model(input bit t, input bit s, input bit l, input logic signed [31:0] ov,
                         input bit p, input logic signed [31:0] pv);
        longint tot;
        logic signed [31:0] o;
        longint mg;
        logic signed [31:0] na, np;
        if (t) begin
            tot = longint'({32'd0, m_frac}) + longint'({32'd0, TICK}) + longint'(m_adj);
            m_frac = tot[31:0];
            if (tot >= 64'sh1_0000_0000) m_time = m_time + 48'd1;
        end
        na = m_adj;
        np = m_pend;
        if (s) begin
            o  = l ? ov : m_pend;
            mg = (longint'(o) < 0) ? -longint'(o) : longint'(o);
            if (mg >= LIM) begin
                na = (o > 0) ? m_adj + 32'(STEP) : m_adj - 32'(STEP);
                np = o;
            end else begin
                na = o >>> SH;
                np = '0;
            end
        end else if (l) np = ov;
        if (p) na = pv;
        m_adj  = na;
        m_pend = np;
    endtask

    task automatic step(input bit t, input bit s, input bit l, input logic [31:0] ov,
                        input bit p, input logic [31:0] pv);
        @(negedge clk);
        tick_i = t; sec_i = s; ofs_load_i = l; ofs_i = ov;
        adj_load_i = p; adj_load_val_i = pv;
        @(posedge clk);
        #1;
        model(t, s, l, ov, p, pv);
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick_i = 0; sec_i = 0; ofs_load_i = 0; adj_load_i = 0;
        repeat (2) @(posedge clk);
        #1;
        m_time = '0; m_frac = '0; m_adj = '0; m_pend = '0;
        tag_time = "R1"; tag_frac = "R1"; tag_adj = "R1"; tag_pend = "R1";
        compare_all();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        compare_all();
        tag_time = "R4"; tag_frac = "R3"; tag_adj = "R10"; tag_pend = "R5";
    endtask

    initial begin
        m_time = '0; m_frac = '0; m_adj = '0; m_pend = '0;
        do_reset();

        // R5: load without strobe
        step(0, 0, 1, 32'd500, 0, '0);
        step(0, 0, 0, '0, 0, '0);

        // R8: combined load and strobe, sweeping offsets around the limit
        for (int v = -140; v <= 140; v++) begin
            step(0, 0, 1, 32'd777, 0, '0);
            tag_adj = (v >= LIM || v <= -LIM) ? "R6" : "R7";
            tag_pend = "R8";
            step(0, 1, 1, 32'(v), 0, '0);
            tag_adj = "R10"; tag_pend = "R5";
        end
        tag_adj = "R6"; tag_pend = "R6";
        step(0, 1, 1, 32'h7FFF_FFFF, 0, '0);
        step(0, 1, 1, 32'h8000_0000, 0, '0);

        // R6: large offset slews repeatedly, both signs
        step(0, 0, 1, 32'd300, 0, '0);
        for (int k = 0; k < 5; k++) step(0, 1, 0, '0, 0, '0);
        step(0, 0, 1, 32'hFFFF_FED4, 0, '0);
        for (int k = 0; k < 5; k++) step(0, 1, 0, '0, 0, '0);
        tag_adj = "R7"; tag_pend = "R7";
        step(0, 0, 1, 32'd100, 0, '0);
        step(0, 1, 0, '0, 0, '0);

        // R2: preload wins over a strobe
        tag_adj = "R2";
        step(0, 0, 1, 32'd1000, 0, '0);
        step(0, 1, 0, '0, 1, 32'd12345);
        step(0, 0, 0, '0, 1, 32'hFFFF_FFF0);

        // R3 and R4: tick sweeps over several adjustment values
        begin
            logic [31:0] xs [6];
            xs[0] = 32'hC465_3600; // -1e9, produces negative sums
            xs[1] = 32'hFFFF_FFFB;
            xs[2] = 32'd0;
            xs[3] = 32'd7;
            xs[4] = 32'd300000000;
            xs[5] = 32'h7FFF_FFFF;
            for (int i = 0; i < 6; i++) begin
                tag_adj = "R2";
                step(0, 0, 0, '0, 1, xs[i]);
                tag_adj = "R10";
                for (int k = 0; k < 60; k++) step((k % 7) != 3, 0, 0, '0, 0, '0);
            end
        end

        // R4: a negative sum wraps the fraction without a millisecond
        do_reset();
        tag_time = "R4";
        step(0, 0, 0, '0, 1, 32'hC465_3600);
        step(1, 0, 0, '0, 0, '0);
        step(1, 0, 0, '0, 0, '0);

        // R9: tick and strobe together while a large offset is pending
        tag_frac = "R9"; tag_time = "R9"; tag_adj = "R6";
        step(0, 0, 1, 32'd5000, 1, 32'd1000);
        for (int k = 0; k < 8; k++) step(1, 1, 0, '0, 0, '0);
        tag_frac = "R3"; tag_time = "R4"; tag_adj = "R10";
        for (int k = 0; k < 8; k++) step(1, 0, 0, '0, 0, '0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule